// File: doc/BRIEF.md
# Selectable Two-Output Clock Divider

The block takes one input clock and produces two slower clocks from it. A two-bit select code picks the division. The primary output runs at the input frequency divided by 2, 6 or 8. The secondary output always runs at half the primary frequency, so the pairs are /2 and /4, /6 and /12, and /8 and /16. The fourth code stops both outputs and holds them low, which is the power-down state.

Both outputs are registered on the input clock. The secondary output toggles on the same input edge that raises the primary, so its edges line up with the primary's edges. An active-high output enable produces a drive-enable for each output. The chip's output pad cells use these enables to float the pins at high impedance when the enable is low. The divider keeps counting while the outputs float.

A new select code takes effect only at the end of a full primary period, on the edge that drops the primary output. A select change therefore never cuts a high or low phase short. Reset is synchronous.

Top module: `ckdiv_top`

## Requirements
- R1: While reset is high, both clock outputs are low. With a division ratio N selected during reset, the primary output first goes high on the (N/2)-th rising input edge after reset is released.
- R2: With select code 2'b11, the primary output divides the input by 2 and the secondary divides it by 4.
- R3: With select code 2'b01, the primary output divides the input by 6 and the secondary divides it by 12.
- R4: With select code 2'b10, the primary output divides the input by 8 and the secondary divides it by 16.
- R5: The primary output has a 50% duty cycle. It stays high for N/2 input cycles and then low for N/2 input cycles.
- R6: The secondary output toggles only on input edges where the primary output rises. Each secondary rise coincides with a primary rise, on every second primary rise.
- R7: With select code 2'b00, the counters are held cleared and both clock outputs stay low without toggling. This holds both from reset and after switching from a running code.
- R8: Both drive-enable outputs are 1 when the output enable is high and 0 when it is low. The dividers keep running while the outputs are disabled.
- R9: A select change is applied only on the edge where the primary output falls at the end of a full period. A change made during a high phase lets that phase finish at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 2 | Division select code |
| oe | input | 1 | Output enable, active high |
| pri_clk | output | 1 | Primary divided clock |
| pri_clk_en | output | 1 | Drive enable for the primary output pad |
| sec_clk | output | 1 | Secondary clock, half the primary frequency |
| sec_clk_en | output | 1 | Drive enable for the secondary output pad |

## Verification
Each running select code is applied through reset. The bench then records both outputs for four primary periods and compares them cycle by cycle against a waveform computed from the half-ratio alone. This separates the three ratios from one another and exposes a wrong first-edge delay, an uneven duty cycle or a secondary that is off by one primary period. Further directed sequences cover the following cases:
- power-down from reset;
- power-down entered from a running code;
- a select change made in the middle of a high phase, which shows whether the change waits for the period boundary;
- enable toggling while the dividers run, which shows that the drive enables follow the enable and the counting does not stop.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_MID  = 2'b01,
    SEL_SLOW = 2'b10,
    SEL_FAST = 2'b11
  } div_sel_e;

  // Number of input cycles in one phase (high or low) of the primary clock.
  function automatic int unsigned half_of(input int unsigned ratio);
    return ratio / 2;
  endfunction

  // Largest of three ratios, used to size the phase counter.
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/ckdiv_decode.sv
`timescale 1ns/1ps
module ckdiv_decode
  import ckdiv_pkg::*;
#(
  parameter int unsigned RATIO_MID  = 6,
  parameter int unsigned RATIO_SLOW = 8,
  parameter int unsigned RATIO_FAST = 2,
  parameter int unsigned CNT_W      = 3
) (
  input  div_sel_e         code,
  output logic [CNT_W-1:0] last_cnt,
  output logic             pd
);
  localparam logic [CNT_W-1:0] LAST_MID  = CNT_W'(half_of(RATIO_MID)  - 1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(half_of(RATIO_SLOW) - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(half_of(RATIO_FAST) - 1);

  always_comb begin
    pd       = 1'b0;
    last_cnt = '0;
    unique case (code)
      SEL_MID:  last_cnt = LAST_MID;
      SEL_SLOW: last_cnt = LAST_SLOW;
      SEL_FAST: last_cnt = LAST_FAST;
      default:  pd       = 1'b1;
    endcase
  end
endmodule

// File: rtl/ckdiv_primary.sv
`timescale 1ns/1ps
module ckdiv_primary
  import ckdiv_pkg::*;
#(
  parameter int unsigned RATIO_MID  = 6,
  parameter int unsigned RATIO_SLOW = 8,
  parameter int unsigned RATIO_FAST = 2,
  parameter int unsigned CNT_W      = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  div_sel_e sel_in,
  output logic     pri_q,
  output logic     rise_evt,
  output logic     pd_act
);
  div_sel_e         act_sel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             wrap;
  logic             period_end;
  logic             load_sel;

  ckdiv_decode #(
    .RATIO_MID (RATIO_MID),
    .RATIO_SLOW(RATIO_SLOW),
    .RATIO_FAST(RATIO_FAST),
    .CNT_W     (CNT_W)
  ) u_dec (
    .code    (act_sel),
    .last_cnt(last_cnt),
    .pd      (pd_act)
  );

  // Named internal events, exposed for the assertions below.
  assign wrap       = !pd_act && (cnt == last_cnt);
  assign period_end = wrap && pri_q;      // primary about to fall
  assign rise_evt   = wrap && !pri_q;     // primary about to rise
  assign load_sel   = pd_act || period_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pri_q   <= 1'b0;
      act_sel <= sel_in;
    end else begin
      if (load_sel) act_sel <= sel_in;
      if (pd_act) begin
        cnt   <= '0;
        pri_q <= 1'b0;
      end else if (wrap) begin
        cnt   <= '0;
        pri_q <= ~pri_q;
      end else begin
        cnt   <= cnt + 1'b1;
      end
    end
  end

  // R5: the phase counter never passes the phase length of the active ratio
  a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_cnt);

  // R9: the active code only changes after a primary fall, in power-down, or from reset
  a_r9_sel_hold: assert property (@(posedge clk) disable iff (rst)
    (act_sel != $past(act_sel)) |-> (($past(pri_q) && !pri_q) || $past(pd_act) || $past(rst)));

  // R7: once power-down is active, the primary output is held low
  a_r7_pri_quiet: assert property (@(posedge clk) disable iff (rst)
    pd_act |=> !pri_q);
endmodule

// File: rtl/ckdiv_secondary.sv
`timescale 1ns/1ps
module ckdiv_secondary (
  input  logic clk,
  input  logic rst,
  input  logic pd,
  input  logic rise_evt,
  input  logic pri_i,
  output logic sec_q
);
  always_ff @(posedge clk) begin
    if (rst || pd) sec_q <= 1'b0;
    else if (rise_evt) sec_q <= ~sec_q;
  end

  // R6: each secondary rise lands on the same edge as a primary rise
  a_r6_sec_with_pri: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_q) |-> $rose(pri_i));

  // R7: power-down clears the secondary on the following edge
  a_r7_sec_quiet: assert property (@(posedge clk) disable iff (rst)
    pd |=> !sec_q);
endmodule

// File: rtl/ckdiv_top.sv
`timescale 1ns/1ps
module ckdiv_top
  import ckdiv_pkg::*;
#(
  parameter int unsigned RATIO_MID  = 6,
  parameter int unsigned RATIO_SLOW = 8,
  parameter int unsigned RATIO_FAST = 2
) (
  input  logic       clk_in,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       oe,
  output logic       pri_clk,
  output logic       pri_clk_en,
  output logic       sec_clk,
  output logic       sec_clk_en
);
  localparam int unsigned MAX_HALF = half_of(max3(RATIO_MID, RATIO_SLOW, RATIO_FAST));
  localparam int unsigned CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

  logic pri_q;
  logic sec_q;
  logic rise_evt;
  logic pd_act;

  ckdiv_primary #(
    .RATIO_MID (RATIO_MID),
    .RATIO_SLOW(RATIO_SLOW),
    .RATIO_FAST(RATIO_FAST),
    .CNT_W     (CNT_W)
  ) u_pri (
    .clk     (clk_in),
    .rst     (rst),
    .sel_in  (div_sel_e'(sel)),
    .pri_q   (pri_q),
    .rise_evt(rise_evt),
    .pd_act  (pd_act)
  );

  ckdiv_secondary u_sec (
    .clk     (clk_in),
    .rst     (rst),
    .pd      (pd_act),
    .rise_evt(rise_evt),
    .pri_i   (pri_q),
    .sec_q   (sec_q)
  );

  assign pri_clk    = pri_q;
  assign sec_clk    = sec_q;
  assign pri_clk_en = oe;
  assign sec_clk_en = oe;

  // R1: reset leaves both clock outputs low on the next edge
  a_r1_reset_low: assert property (@(posedge clk_in)
    $past(rst) |-> (!pri_clk && !sec_clk));
endmodule

// File: tb/tb_ckdiv_top.sv
`timescale 1ns/1ps
module tb_ckdiv_top;
  logic       clk_in = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       oe = 1'b1;
  logic       pri_clk, pri_clk_en, sec_clk, sec_clk_en;

  int n_chk  = 0;
  int n_fail = 0;
  logic rp [1:64];
  logic rs [1:64];

  always #4 clk_in = ~clk_in;   // 125 MHz

  ckdiv_top dut (
    .clk_in(clk_in), .rst(rst), .sel(sel), .oe(oe),
    .pri_clk(pri_clk), .pri_clk_en(pri_clk_en),
    .sec_clk(sec_clk), .sec_clk_en(sec_clk_en)
  );

  // {select code, phase length in input cycles}
  localparam logic [7:0] VEC [3] = '{ {2'b11, 6'd1}, {2'b01, 6'd3}, {2'b10, 6'd4} };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] s);
    @(negedge clk_in);
    rst = 1'b1;
    sel = s;
    repeat (3) @(negedge clk_in);
    rst = 1'b0;
  endtask

  task automatic capture(input int n);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk_in);
      rp[i] = pri_clk;
      rs[i] = sec_clk;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    start(2'b11);
    @(negedge clk_in);
    rst = 1'b1;
    @(negedge clk_in);
    chk("R1 reset pri", pri_clk, 0);
    chk("R1 reset sec", sec_clk, 0);

    // Vector walk: ratios, first edge, duty, secondary alignment
    for (int v = 0; v < 3; v++) begin
      logic [1:0] s;
      int h, mis_p, mis_s, first, highs, bad_sec;
      string tag;
      s = VEC[v][7:6];
      h = int'(VEC[v][5:0]);
      tag = (s == 2'b11) ? "R2" : (s == 2'b01) ? "R3" : "R4";
      start(s);
      capture(8 * h);
      mis_p = 0; mis_s = 0; first = 0; highs = 0; bad_sec = 0;
      for (int i = 1; i <= 8 * h; i++) begin
        int ep, es;
        ep = (i / h) % 2;
        es = (((i / h) + 1) / 2) % 2;
        if (int'(rp[i]) != ep) mis_p++;
        if (int'(rs[i]) != es) mis_s++;
        if (first == 0 && rp[i]) first = i;
        if (i > 4 * h && rp[i]) highs++;
        if (i > 1 && rs[i] && !rs[i-1] && !(rp[i] && !rp[i-1])) bad_sec++;
      end
      chk({tag, " primary waveform mismatches"}, mis_p, 0);
      chk({tag, " secondary waveform mismatches"}, mis_s, 0);
      chk("R1 first primary rise edge", first, h);
      chk("R5 primary high cycles per two periods", highs, 2 * h);
      chk("R6 secondary rises without primary rise", bad_sec, 0);
    end

    // R7: power-down from reset
    begin
      int act;
      start(2'b00);
      capture(20);
      act = 0;
      for (int i = 1; i <= 20; i++) if (rp[i] || rs[i]) act++;
      chk("R7 power-down from reset activity", act, 0);
    end

    // R7: power-down entered from a running code
    begin
      int act;
      start(2'b01);
      capture(10);
      sel = 2'b00;
      capture(12);
      act = 0;
      for (int i = 7; i <= 12; i++) if (rp[i] || rs[i]) act++;
      chk("R7 power-down after running activity", act, 0);
    end

    // R8: enable gating, dividers keep running
    begin
      int tog;
      start(2'b11);
      capture(3);
      oe = 1'b0;
      @(negedge clk_in);
      chk("R8 pri enable low", pri_clk_en, 0);
      chk("R8 sec enable low", sec_clk_en, 0);
      capture(8);
      tog = 0;
      for (int i = 2; i <= 8; i++) if (rp[i] != rp[i-1]) tog++;
      chk("R8 primary toggles while disabled", tog, 7);
      oe = 1'b1;
      @(negedge clk_in);
      chk("R8 pri enable high", pri_clk_en, 1);
      chk("R8 sec enable high", sec_clk_en, 1);
    end

    // R9: select change in a high phase waits for the period end
    start(2'b10);
    capture(5);
    sel = 2'b11;
    for (int i = 6; i <= 11; i++) begin
      @(negedge clk_in);
      rp[i] = pri_clk;
    end
    chk("R9 high phase holds edge 6", rp[6], 1);
    chk("R9 high phase holds edge 7", rp[7], 1);
    chk("R9 falls at period end edge 8", rp[8], 0);
    chk("R9 new ratio rise edge 9", rp[9], 1);
    chk("R9 new ratio fall edge 10", rp[10], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule